// File: doc/BRIEF.md
# Software-Refilled Translation Buffer with Fixed Region Decode

This block turns a 32-bit virtual address into a physical address for a processor whose page tables are walked entirely by software. It keeps a set of translation entries, compared all at once against every lookup. Each entry is tagged with an address-space identifier so that several processes can share the array without a flush on every context switch. Pages are 4 KiB: bits 31:12 of the address form the page number and bits 11:0 pass through unchanged.

A fixed decoder splits the 4 GiB space into four regions by the top address bits. The lower half is the user region and is translated. The top quarter is kernel-only and translated. The two eighths in between are kernel-only windows onto physical memory: one is cacheable and one is not. In both windows the physical address is the virtual address with bits 31:29 cleared.

A lookup that finds no entry reports a miss fault, and nothing else happens. The hardware walks no page table. Software handles the fault, then loads the entry through an indexed write port. Two commands remove entries. One drops every entry that matches a given page number and identifier. The other drops all entries at once.

Top module: `soft_tlb`

## Requirements
- R1: A lookup with `lk_user`=1 and `lk_vaddr[31]`=1 returns fault code 3 (address error), whatever the array holds.
- R2: A kernel lookup in 0x80000000–0xBFFFFFFF returns fault code 0 and `pa` = `lk_vaddr` with bits 31:29 cleared. `pa_cacheable` is 1 for 0x80000000–0x9FFFFFFF and 0 for 0xA0000000–0xBFFFFFFF.
- R3: A lookup in 0x00000000–0x7FFFFFFF (any mode) or 0xC0000000–0xFFFFFFFF (kernel) hits an entry when that entry is valid, its page number equals `lk_vaddr[31:12]` and its identifier equals `cur_asid`. On a hit, `pa` = {entry page, `lk_vaddr[11:0]`}, `pa_cacheable` = 1 and the fault code is 0.
- R4: A translated lookup with no hit returns fault code 1 (miss). Whenever the fault code is not 0, `pa` is 0 and `pa_cacheable` is 0.
- R5: A write (`lk_write`=1) that hits an entry whose writable bit is 0 returns fault code 2 (modify). A read of the same entry succeeds.
- R6: When several valid entries match, the one with the lowest index supplies the translation.
- R7: With `wr_en`=1 at a rising edge, the entry at `wr_index` takes `wr_vpn`, `wr_ppn`, `wr_asid`, `wr_valid` and `wr_writable`. Lookups from the next cycle on use the new contents. Lookups are combinational, so results come in the same cycle.
- R8: With `inv_en`=1 at a rising edge, every valid entry whose page number equals `inv_vpn` and whose identifier equals `inv_asid` becomes invalid. All other entries are kept.
- R9: With `inv_all`=1 at a rising edge, every entry becomes invalid. In the same cycle, an invalidate overrides a write to the same entry.
- R10: After reset every entry is invalid, so any translated lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_write | input | 1 | 1 = store access, 0 = load |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| cur_asid | input | ASID_W | Current address-space identifier |
| wr_en | input | 1 | Load one entry |
| wr_index | input | IDX_W | Entry slot to load |
| wr_vpn | input | 20 | Virtual page number to load |
| wr_ppn | input | 20 | Physical page number to load |
| wr_asid | input | ASID_W | Identifier tag to load |
| wr_valid | input | 1 | Valid bit to load |
| wr_writable | input | 1 | Writable bit to load |
| inv_en | input | 1 | Invalidate entries matching page and identifier |
| inv_vpn | input | 20 | Page number to invalidate |
| inv_asid | input | ASID_W | Identifier to invalidate |
| inv_all | input | 1 | Invalidate every entry |
| pa | output | 32 | Physical address |
| pa_cacheable | output | 1 | Access may be cached |
| fault_code | output | 2 | 0 none, 1 miss, 2 modify, 3 address error |

## Verification
Some properties are checked on every cycle. These are the user address-error rule, the direct-window address arithmetic and cacheability, the zeroed outputs on any fault, and that a modify fault only ever comes with a write. The checker also follows each slot's valid bit after loads and after an invalidate-all. Other behaviours need a known sequence of loads, so only the bench scenarios show them. These are identifier isolation, the lowest-index choice among duplicates, selective invalidation that spares other entries, the extreme slots 0 and 63, and an invalidate that wins over a write to the same slot.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;
  localparam int VA_W      = 32;
  localparam int PG_SHIFT  = 12;
  localparam int PN_W      = VA_W - PG_SHIFT;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_MISS = 2'd1,
    FLT_MOD  = 2'd2,
    FLT_ADDR = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    RG_USER    = 2'd0,
    RG_DIR_C   = 2'd1,
    RG_DIR_U   = 2'd2,
    RG_KMAPPED = 2'd3
  } region_e;
endpackage

// File: rtl/soft_tlb_region.sv
module soft_tlb_region
  import soft_tlb_pkg::*;
(
  input  logic [VA_W-1:0] vaddr,
  output region_e         region,
  output logic            translated,
  output logic            kern_only
);
  always_comb begin
    if (!vaddr[31])          region = RG_USER;
    else if (vaddr[30])      region = RG_KMAPPED;
    else if (vaddr[29])      region = RG_DIR_U;
    else                     region = RG_DIR_C;
  end

  assign translated = (region == RG_USER) || (region == RG_KMAPPED);
  assign kern_only  = (region != RG_USER);
endmodule

// File: rtl/soft_tlb_slot.sv
module soft_tlb_slot
  import soft_tlb_pkg::*;
#(
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [PN_W-1:0]   ld_vpn,
  input  logic [PN_W-1:0]   ld_ppn,
  input  logic [ASID_W-1:0] ld_asid,
  input  logic              ld_valid,
  input  logic              ld_writable,
  input  logic              inv_en,
  input  logic [PN_W-1:0]   inv_vpn,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic              inv_all,
  input  logic [PN_W-1:0]   q_vpn,
  input  logic [ASID_W-1:0] q_asid,
  output logic              match,
  output logic [PN_W-1:0]   ppn,
  output logic              writable,
  output logic              valid
);
  logic [PN_W-1:0]   vpn_q;
  logic [PN_W-1:0]   ppn_q;
  logic [ASID_W-1:0] asid_q;
  logic              wrb_q;
  logic              vld_q;
  logic              vld_d;
  logic              vld_ce;
  logic              kill;

  // Next-state for the valid bit: any invalidate beats a load
  always_comb begin
    kill   = inv_all || (inv_en && vld_q && (vpn_q == inv_vpn) && (asid_q == inv_asid));
    vld_ce = kill || ld;
    vld_d  = kill ? 1'b0 : ld_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vld_q <= 1'b0;
    else if (vld_ce) vld_q <= vld_d;
  end

  // Payload fields carry no reset; they are only read when valid
  always_ff @(posedge clk) begin
    if (ld) begin
      vpn_q  <= ld_vpn;
      ppn_q  <= ld_ppn;
      asid_q <= ld_asid;
      wrb_q  <= ld_writable;
    end
  end

  assign match    = vld_q && (vpn_q == q_vpn) && (asid_q == q_asid);
  assign ppn      = ppn_q;
  assign writable = wrb_q;
  assign valid    = vld_q;
endmodule

// File: rtl/soft_tlb_pick.sv
module soft_tlb_pick #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // Scan from the top so the lowest set bit is written last
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
  import soft_tlb_pkg::*;
#(
  parameter int N_ENTRIES = 64,
  parameter int ASID_W    = 8,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       lk_vaddr,
  input  logic              lk_write,
  input  logic              lk_user,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [19:0]       wr_vpn,
  input  logic [19:0]       wr_ppn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_valid,
  input  logic              wr_writable,
  input  logic              inv_en,
  input  logic [19:0]       inv_vpn,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic              inv_all,
  output logic [31:0]       pa,
  output logic              pa_cacheable,
  output logic [1:0]        fault_code
);
  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // Region decode
  region_e rgn;
  logic    rgn_xlat;
  logic    rgn_kern;

  soft_tlb_region u_region (
    .vaddr      (lk_vaddr),
    .region     (rgn),
    .translated (rgn_xlat),
    .kern_only  (rgn_kern)
  );

  // Entry array
  logic [N_ENTRIES-1:0] hit_vec;
  logic [N_ENTRIES-1:0] vld_vec;
  logic [N_ENTRIES-1:0] wrb_vec;
  logic [PN_W-1:0]      ppn_arr [N_ENTRIES];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
    soft_tlb_slot #(.ASID_W(ASID_W)) u_slot (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .ld          (wr_en && (wr_index == IDX_W'(g))),
      .ld_vpn      (wr_vpn),
      .ld_ppn      (wr_ppn),
      .ld_asid     (wr_asid),
      .ld_valid    (wr_valid),
      .ld_writable (wr_writable),
      .inv_en      (inv_en),
      .inv_vpn     (inv_vpn),
      .inv_asid    (inv_asid),
      .inv_all     (inv_all),
      .q_vpn       (lk_vaddr[31:PG_SHIFT]),
      .q_asid      (cur_asid),
      .match       (hit_vec[g]),
      .ppn         (ppn_arr[g]),
      .writable    (wrb_vec[g]),
      .valid       (vld_vec[g])
    );
  end

  logic             hit_any;
  logic [IDX_W-1:0] hit_idx;

  soft_tlb_pick #(.N(N_ENTRIES)) u_pick (
    .req (hit_vec),
    .any (hit_any),
    .idx (hit_idx)
  );

  // Result: address error first, then direct windows, then array result
  fault_e flt;
  always_comb begin
    pa           = '0;
    pa_cacheable = 1'b0;
    flt          = FLT_NONE;
    if (lk_user && rgn_kern) begin
      flt = FLT_ADDR;
    end else if (!rgn_xlat) begin
      pa           = {3'b000, lk_vaddr[28:0]};
      pa_cacheable = (rgn == RG_DIR_C);
    end else if (!hit_any) begin
      flt = FLT_MISS;
    end else if (lk_write && !wrb_vec[hit_idx]) begin
      flt = FLT_MOD;
    end else begin
      pa           = {ppn_arr[hit_idx], lk_vaddr[PG_SHIFT-1:0]};
      pa_cacheable = 1'b1;
    end
  end
  assign fault_code = flt;
endmodule

// File: rtl/soft_tlb_chk.sv
module soft_tlb_chk #(
  parameter int N_ENTRIES = 64,
  parameter int ASID_W    = 8,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [31:0]          lk_vaddr,
  input logic                 lk_write,
  input logic                 lk_user,
  input logic                 wr_en,
  input logic [IDX_W-1:0]     wr_index,
  input logic                 wr_valid,
  input logic                 inv_en,
  input logic                 inv_all,
  input logic [31:0]          pa,
  input logic                 pa_cacheable,
  input logic [1:0]           fault_code,
  input logic [N_ENTRIES-1:0] vld
);
  // R1
  user_addr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_user && lk_vaddr[31]) |-> (fault_code == 2'd3));

  // R2
  direct_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_user && lk_vaddr[31:30] == 2'b10) |->
      (fault_code == 2'd0 && pa == {3'b000, lk_vaddr[28:0]} && pa_cacheable == !lk_vaddr[29]));

  // R3
  mapped_cacheable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code == 2'd0 && lk_vaddr[31:30] != 2'b10) |-> pa_cacheable);

  // R4
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code != 2'd0) |-> (pa == 32'd0 && !pa_cacheable));

  // R5
  modify_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code == 2'd2) |-> lk_write);

  // R7
  load_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !inv_en && !inv_all) |=> (vld[$past(wr_index)] == $past(wr_valid)));

  // R9
  flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (vld == '0));
endmodule

bind soft_tlb soft_tlb_chk #(.N_ENTRIES(N_ENTRIES), .ASID_W(ASID_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .lk_vaddr     (lk_vaddr),
  .lk_write     (lk_write),
  .lk_user      (lk_user),
  .wr_en        (wr_en),
  .wr_index     (wr_index),
  .wr_valid     (wr_valid),
  .inv_en       (inv_en),
  .inv_all      (inv_all),
  .pa           (pa),
  .pa_cacheable (pa_cacheable),
  .fault_code   (fault_code),
  .vld          (vld_vec)
);

// File: tb/soft_tlb_tb_top.sv
module soft_tlb_tb_top;
  localparam int N  = 64;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [31:0]   lk_vaddr;
  logic          lk_write, lk_user;
  logic [AW-1:0] cur_asid;
  logic          wr_en;
  logic [5:0]    wr_index;
  logic [19:0]   wr_vpn, wr_ppn;
  logic [AW-1:0] wr_asid;
  logic          wr_valid, wr_writable;
  logic          inv_en, inv_all;
  logic [19:0]   inv_vpn;
  logic [AW-1:0] inv_asid;
  logic [31:0]   pa;
  logic          pa_cacheable;
  logic [1:0]    fault_code;

  always #10 clk = ~clk;

  soft_tlb dut_i (
    .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_write(lk_write),
    .lk_user(lk_user), .cur_asid(cur_asid), .wr_en(wr_en), .wr_index(wr_index),
    .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .wr_asid(wr_asid), .wr_valid(wr_valid),
    .wr_writable(wr_writable), .inv_en(inv_en), .inv_vpn(inv_vpn),
    .inv_asid(inv_asid), .inv_all(inv_all), .pa(pa),
    .pa_cacheable(pa_cacheable), .fault_code(fault_code)
  );

  // Reference contents, kept from the requirements
  logic          m_vld [N];
  logic [19:0]   m_vpn [N];
  logic [19:0]   m_ppn [N];
  logic [AW-1:0] m_asid[N];
  logic          m_wrb [N];

  typedef struct {
    logic [31:0] pa;
    logic        cach;
    logic [1:0]  flt;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  event smp_ev;
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  function automatic exp_t model(input logic [31:0] va, input logic w,
                                 input logic u, input logic [AW-1:0] a);
    exp_t e;
    int   sel;
    e.pa = '0; e.cach = 1'b0; e.flt = 2'd0; sel = -1;
    if (u && va[31]) begin
      e.flt = 2'd3;
    end else if (va[31:30] == 2'b10) begin
      e.pa   = va & 32'h1FFF_FFFF;
      e.cach = ~va[29];
    end else begin
      for (int i = N - 1; i >= 0; i--)
        if (m_vld[i] && m_vpn[i] == va[31:12] && m_asid[i] == a) sel = i;
      if (sel < 0)            e.flt = 2'd1;
      else if (w && !m_wrb[sel]) e.flt = 2'd2;
      else begin
        e.pa   = {m_ppn[sel], va[11:0]};
        e.cach = 1'b1;
      end
    end
    return e;
  endfunction

  task automatic lookup(input logic [31:0] va, input logic w, input logic u,
                        input logic [AW-1:0] a, input string tag);
    exp_t e;
    @(negedge clk);
    lk_vaddr = va; lk_write = w; lk_user = u; cur_asid = a;
    e = model(va, w, u, a);
    e.tag = tag;
    exp_q.push_back(e);
    #5;
    -> smp_ev;
  endtask

  task automatic load(input int idx, input logic [19:0] vpn, input logic [19:0] ppn,
                      input logic [AW-1:0] a, input logic v, input logic wb);
    @(negedge clk);
    wr_en = 1'b1; wr_index = 6'(idx); wr_vpn = vpn; wr_ppn = ppn;
    wr_asid = a; wr_valid = v; wr_writable = wb;
    @(negedge clk);
    wr_en = 1'b0;
    if (!(inv_all || (inv_en && m_vld[idx] && m_vpn[idx] == inv_vpn && m_asid[idx] == inv_asid))) begin
      m_vld[idx] = v; m_vpn[idx] = vpn; m_ppn[idx] = ppn; m_asid[idx] = a; m_wrb[idx] = wb;
    end
  endtask

  task automatic drop(input logic [19:0] vpn, input logic [AW-1:0] a);
    @(negedge clk);
    inv_en = 1'b1; inv_vpn = vpn; inv_asid = a;
    @(negedge clk);
    inv_en = 1'b0;
    for (int i = 0; i < N; i++)
      if (m_vld[i] && m_vpn[i] == vpn && m_asid[i] == a) m_vld[i] = 1'b0;
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      exp_t e;
      @(smp_ev);
      e = exp_q.pop_front();
      n_chk++;
      if (pa !== e.pa || pa_cacheable !== e.cach || fault_code !== e.flt) begin
        n_fail++;
        $display("FAIL %s: got pa=%h cach=%b flt=%0d, expected pa=%h cach=%b flt=%0d",
                 e.tag, pa, pa_cacheable, fault_code, e.pa, e.cach, e.flt);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    rst_n = 1'b0;
    lk_vaddr = '0; lk_write = 0; lk_user = 0; cur_asid = '0;
    wr_en = 0; wr_index = '0; wr_vpn = '0; wr_ppn = '0; wr_asid = '0;
    wr_valid = 0; wr_writable = 0; inv_en = 0; inv_vpn = '0; inv_asid = '0; inv_all = 0;
    #45 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: empty after reset
    lookup(32'h0000_1234, 0, 0, 8'd0, "R10 user miss after reset");
    lookup(32'hC000_0000, 0, 0, 8'd0, "R10 kmapped miss after reset");
    // R2: direct windows
    lookup(32'h8001_2345, 0, 0, 8'd0, "R2 cached window");
    lookup(32'hBFFF_FFFF, 1, 0, 8'd0, "R2 uncached window top");
    // R1: user touching kernel space
    lookup(32'h8000_0000, 0, 1, 8'd0, "R1 user at boundary");
    lookup(32'hA000_0010, 1, 1, 8'd0, "R1 user uncached window");

    // R7, R3: load and hit
    load(5, 20'h00400, 20'h12345, 8'd3, 1, 1);
    lookup(32'h0040_0ABC, 1, 1, 8'd3, "R3 user write hit");
    lookup(32'h0040_0ABC, 0, 0, 8'd3, "R3 kernel reading user page");
    lookup(32'h0040_0ABC, 0, 1, 8'd4, "R4 other asid misses");
    lookup(32'h0040_1000, 0, 1, 8'd3, "R4 neighbouring page misses");

    // R5: read-only page
    load(7, 20'h00401, 20'h0BEEF, 8'd3, 1, 0);
    lookup(32'h0040_1004, 0, 1, 8'd3, "R5 read of read-only page");
    lookup(32'h0040_1004, 1, 1, 8'd3, "R5 write of read-only page");

    // R6: duplicates, lowest index wins
    load(9, 20'h00500, 20'h0BBBB, 8'd3, 1, 1);
    load(2, 20'h00500, 20'h0AAAA, 8'd3, 1, 1);
    lookup(32'h0050_0010, 0, 1, 8'd3, "R6 lowest index wins");

    // R3 slot boundaries 0 and 63, kernel mapped region
    load(63, 20'hC0002, 20'h00777, 8'd1, 1, 1);
    load(0, 20'hFFFFF, 20'h00001, 8'd1, 1, 1);
    lookup(32'hC000_2FFF, 1, 0, 8'd1, "R3 kmapped slot 63");
    lookup(32'hFFFF_F000, 0, 0, 8'd1, "R3 top page slot 0");
    lookup(32'hC000_2000, 0, 1, 8'd1, "R1 user at mapped kernel entry");

    // R7: load with valid clear
    load(11, 20'h00600, 20'h00600, 8'd3, 0, 1);
    lookup(32'h0060_0000, 0, 1, 8'd3, "R7 invalid load misses");

    // R8: selective invalidate
    drop(20'h00500, 8'd4);
    lookup(32'h0050_0010, 0, 1, 8'd3, "R8 wrong asid invalidate spares");
    drop(20'h00500, 8'd3);
    lookup(32'h0050_0010, 0, 1, 8'd3, "R8 both duplicates dropped");
    lookup(32'h0040_0ABC, 0, 1, 8'd3, "R8 other entry kept");

    // R9: invalidate beats load to same slot, then flush all
    @(negedge clk);
    inv_all = 1'b1;
    wr_en = 1'b1; wr_index = 6'd20; wr_vpn = 20'h00700; wr_ppn = 20'h00070;
    wr_asid = 8'd3; wr_valid = 1; wr_writable = 1;
    @(negedge clk);
    inv_all = 1'b0; wr_en = 1'b0;
    for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    lookup(32'h0070_0000, 0, 1, 8'd3, "R9 flush overrides load");
    lookup(32'h0040_0ABC, 0, 1, 8'd3, "R9 flush clears user entry");
    lookup(32'hC000_2000, 0, 0, 8'd1, "R9 flush clears slot 63");
    lookup(32'h9FFF_FFFF, 0, 0, 8'd0, "R2 cached window top");

    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule